// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

This block gathers 32 interrupt inputs and presents them to a processor as two request lines and a wake line. Each source is given a trigger code, an enable (mask) bit, a wake-enable bit and a routing bit. A simple synchronous register bus reaches all of them. Every configuration register has its own set address, clear address and read-back address. Software can therefore turn single bits on or off without first reading the register.

Inputs pass through a two-flop synchroniser. Rising and falling transitions are then latched in two capture registers. Software acknowledges an edge by writing ones to the clear address of those registers. Level sources are pending for as long as the input holds the selected polarity.

A pending source that is unmasked shows in the status register of the line its routing bit selects. The request output of that line is high while its status register is nonzero. A source-select register and a test register are plain storage.

Top module: `irqc_top`

## Requirements
- R1: After reset the trigger, mask, wake and capture registers read 0, the routing register reads 0xFFFFFFFF, and irq_req0, irq_req1 and irq_wake are low.
- R2: For each of the three trigger registers and the mask, wake, routing and source-select registers, writing to the set address (register base + 1) ORs the data into the register and writing to the clear address (base + 2) clears the bits that are one in the data. The read-back address (base + 0) returns the value. The bases are trig0 0x00, trig1 0x04, trig2 0x08, mask 0x0C, wake 0x10, route 0x14 and srcsel 0x18, given as word addresses.
- R3: A source's trigger code is {trig2[i],trig1[i],trig0[i]}. Code 101 makes the source pending while the synchronised input is 1. Code 110 makes it pending while the input is 0.
- R4: Code 001 latches a rising edge in the rise capture register (read at 0x1C). Code 010 latches a falling edge in the fall capture register (read at 0x20). Code 011 latches both. A latched bit stays set after the input returns, and the source is pending while a capture bit of an enabled edge is set.
- R5: Writing ones to 0x1D clears rise capture bits and writing ones to 0x21 clears fall capture bits. Zero bits in the data leave the capture bits unchanged.
- R6: Codes 000, 100 and 111 never make a source pending and never latch edges.
- R7: A routing bit of 1 sends the source to line 0 and a routing bit of 0 sends it to line 1. Status 0 (read at 0x28) and status 1 (read at 0x29) read pending & mask for the sources on each line, and irq_reqN is high while status N is nonzero.
- R8: A source whose mask bit is 0 is absent from both status registers, but its edges are still latched.
- R9: irq_wake is high while any pending source has its wake bit set, whatever its mask bit.
- R10: The test register (write 0x25, read 0x24) and the source-select register only store data and have no effect on any output.
- R11: A level change on src_in shows on a request output after the second rising clock edge following the change, and not after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Asynchronous interrupt source inputs |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req0 | output | 1 | Request line 0 |
| irq_req1 | output | 1 | Request line 1 |
| irq_wake | output | 1 | Wake request |

## Verification
The hardest situation to reach from the ports is an edge that has been latched while its source was masked or while the input had already returned to its idle level. In that case the capture register holds state that no input level reflects. The bench produces this with single-cycle pulses on src_in while the mask bit is clear. It then unmasks the source, or writes a zero-bit clear followed by a one-bit clear. This shows that the latched bit alone, and not the input, drives the request line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W  = 6;
  localparam int NUM_CFG = 7;

  localparam int IDX_TRIG0  = 0;
  localparam int IDX_TRIG1  = 1;
  localparam int IDX_TRIG2  = 2;
  localparam int IDX_MASK   = 3;
  localparam int IDX_WAKE   = 4;
  localparam int IDX_ROUTE  = 5;
  localparam int IDX_SRCSEL = 6;

  localparam logic [ADDR_W-1:0] A_RISE_RD  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_RISE_CLR = 6'h1D;
  localparam logic [ADDR_W-1:0] A_FALL_RD  = 6'h20;
  localparam logic [ADDR_W-1:0] A_FALL_CLR = 6'h21;
  localparam logic [ADDR_W-1:0] A_TEST_RD  = 6'h24;
  localparam logic [ADDR_W-1:0] A_TEST_WR  = 6'h25;
  localparam logic [ADDR_W-1:0] A_STAT0    = 6'h28;
  localparam logic [ADDR_W-1:0] A_STAT1    = 6'h29;

  localparam logic [2:0] TRG_OFF  = 3'b000;
  localparam logic [2:0] TRG_RISE = 3'b001;
  localparam logic [2:0] TRG_FALL = 3'b010;
  localparam logic [2:0] TRG_BOTH = 3'b011;
  localparam logic [2:0] TRG_HIGH = 3'b101;
  localparam logic [2:0] TRG_LOW  = 3'b110;

  // offset 0 = read-back, 1 = set, 2 = clear
  function automatic logic [ADDR_W-1:0] grp_addr(int grp, int off);
    return ADDR_W'(grp * 4 + off);
  endfunction

  function automatic logic trig_rise_on(logic [2:0] code);
    return (code == TRG_RISE) || (code == TRG_BOTH);
  endfunction

  function automatic logic trig_fall_on(logic [2:0] code);
    return (code == TRG_FALL) || (code == TRG_BOTH);
  endfunction

  function automatic logic trig_pending(logic [2:0] code, logic lvl,
                                        logic rcap, logic fcap);
    case (code)
      TRG_RISE: return rcap;
      TRG_FALL: return fcap;
      TRG_BOTH: return rcap | fcap;
      TRG_HIGH: return lvl;
      TRG_LOW:  return ~lvl;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign sync_o = stage2_q;
  assign rise_o = stage2_q & ~prev_q;
  assign fall_o = ~stage2_q & prev_q;
endmodule

// File: rtl/irqc_cfg_reg.sv
module irqc_cfg_reg #(
  parameter int W        = 32,
  parameter bit RST_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= RST_VAL;
    else if (set_en) q <= q | wdata;
    else if (clr_en) q <= q & ~wdata;
  end

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(wdata)) == $past(wdata)));
  // R2
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(wdata)) == '0));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
  import irqc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] trig0,
  input  logic [W-1:0] trig1,
  input  logic [W-1:0] trig2,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_ev,
  input  logic [W-1:0] fall_ev,
  input  logic [W-1:0] rise_clr,
  input  logic [W-1:0] fall_clr,
  output logic [W-1:0] rise_cap,
  output logic [W-1:0] fall_cap,
  output logic [W-1:0] pend
);
  logic [W-1:0] rise_nxt, fall_nxt;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      logic [2:0] code;
      code = {trig2[i], trig1[i], trig0[i]};
      // a new edge wins over a clear in the same cycle
      rise_nxt[i] = (rise_ev[i] & trig_rise_on(code)) | (rise_cap[i] & ~rise_clr[i]);
      fall_nxt[i] = (fall_ev[i] & trig_fall_on(code)) | (fall_cap[i] & ~fall_clr[i]);
      pend[i]     = trig_pending(code, lvl[i], rise_cap[i], fall_cap[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_cap <= '0;
      fall_cap <= '0;
    end else begin
      rise_cap <= rise_nxt;
      fall_cap <= fall_nxt;
    end
  end

  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise_cap & ~$past(rise_cap) & ~$past(lvl)) == '0));
  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_clr == '0) |=> ((rise_cap & $past(rise_cap)) == $past(rise_cap)));
endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] route,
  input  logic [W-1:0] wake_en,
  output logic [W-1:0] stat0,
  output logic [W-1:0] stat1,
  output logic         req0,
  output logic         req1,
  output logic         wake
);
  assign stat0 = pend & mask & route;
  assign stat1 = pend & mask & ~route;
  assign req0  = |stat0;
  assign req1  = |stat1;
  assign wake  = |(pend & wake_en);

  // R7
  line_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat0 & stat1) == '0);
  // R8
  req_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req0 || req1) |-> (mask != '0));
  // R9
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ((wake_en & pend) != '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              irq_req0,
  output logic              irq_req1,
  output logic              irq_wake
);
  logic [NSRC-1:0] cfg_q [NUM_CFG];
  logic [NSRC-1:0] lvl, rise_ev, fall_ev;
  logic [NSRC-1:0] rise_cap, fall_cap, pend;
  logic [NSRC-1:0] rise_clr, fall_clr;
  logic [NSRC-1:0] stat0, stat1;
  logic [NSRC-1:0] test_q;

  irqc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(src_in),
    .sync_o(lvl), .rise_o(rise_ev), .fall_o(fall_ev)
  );

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    irqc_cfg_reg #(.W(NSRC), .RST_ONES(k == IDX_ROUTE)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_en(bus_wr && (bus_addr == grp_addr(k, 1))),
      .clr_en(bus_wr && (bus_addr == grp_addr(k, 2))),
      .wdata (bus_wdata),
      .q     (cfg_q[k])
    );
  end

  assign rise_clr = (bus_wr && bus_addr == A_RISE_CLR) ? bus_wdata : '0;
  assign fall_clr = (bus_wr && bus_addr == A_FALL_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                               test_q <= '0;
    else if (bus_wr && bus_addr == A_TEST_WR) test_q <= bus_wdata;
  end

  irqc_detect #(.W(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_n),
    .trig0(cfg_q[IDX_TRIG0]), .trig1(cfg_q[IDX_TRIG1]), .trig2(cfg_q[IDX_TRIG2]),
    .lvl(lvl), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .rise_clr(rise_clr), .fall_clr(fall_clr),
    .rise_cap(rise_cap), .fall_cap(fall_cap), .pend(pend)
  );

  irqc_route #(.W(NSRC)) u_route (
    .clk(clk), .rst_n(rst_n),
    .pend(pend), .mask(cfg_q[IDX_MASK]), .route(cfg_q[IDX_ROUTE]),
    .wake_en(cfg_q[IDX_WAKE]),
    .stat0(stat0), .stat1(stat1),
    .req0(irq_req0), .req1(irq_req1), .wake(irq_wake)
  );

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_CFG; k++)
      if (bus_addr == grp_addr(k, 0)) bus_rdata = cfg_q[k];
    case (bus_addr)
      A_RISE_RD: bus_rdata = rise_cap;
      A_FALL_RD: bus_rdata = fall_cap;
      A_TEST_RD: bus_rdata = test_q;
      A_STAT0:   bus_rdata = stat0;
      A_STAT1:   bus_rdata = stat1;
      default:   ;
    endcase
  end
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req0, irq_req1, irq_wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [5:0] T0 = 6'h00, T1 = 6'h04, T2 = 6'h08, MSK = 6'h0C,
                         WAK = 6'h10, RTE = 6'h14, SSEL = 6'h18,
                         RISE = 6'h1C, FALL = 6'h20, TST = 6'h24,
                         ST0 = 6'h28, ST1 = 6'h29;

  always #(CLK_P/2) clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req0(irq_req0), .irq_req1(irq_req1), .irq_wake(irq_wake)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    src_in = '0; bus_wr = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // code c on source s: trig2 base 0x08, trig1 0x04, trig0 0x00
  task automatic set_code(int s, logic [2:0] c);
    wr(T0 + (c[0] ? 1 : 2), 32'h1 << s);
    wr(T1 + (c[1] ? 1 : 2), 32'h1 << s);
    wr(T2 + (c[2] ? 1 : 2), 32'h1 << s);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(T0, v);  chk("R1 trig0", v, 0);
    rd(T1, v);  chk("R1 trig1", v, 0);
    rd(T2, v);  chk("R1 trig2", v, 0);
    rd(MSK, v); chk("R1 mask", v, 0);
    rd(WAK, v); chk("R1 wake", v, 0);
    rd(RTE, v); chk("R1 route", v, 32'hFFFF_FFFF);
    rd(RISE, v); chk("R1 rise", v, 0);
    rd(FALL, v); chk("R1 fall", v, 0);
    chk("R1 outputs", {29'd0, irq_req0, irq_req1, irq_wake}, 0);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    do_reset();
    wr(MSK + 1, 32'hF0F0_00FF);
    rd(MSK, v); chk("R2 mask set", v, 32'hF0F0_00FF);
    wr(MSK + 1, 32'h0000_0000);
    rd(MSK, v); chk("R2 zero set no change", v, 32'hF0F0_00FF);
    wr(MSK + 2, 32'h8000_000F);
    rd(MSK, v); chk("R2 mask clear", v, 32'h70F0_00F0);
    wr(RTE + 2, 32'h0000_FFFF);
    rd(RTE, v); chk("R2 route clear", v, 32'hFFFF_0000);
    wr(T1 + 1, 32'h0000_0300);
    rd(T1, v); chk("R2 trig1 set", v, 32'h0000_0300);
    rd(T0, v); chk("R2 trig0 untouched", v, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_reset();
    set_code(3, 3'b101);
    wr(MSK + 1, 32'h18);
    chk("R3 high idle", {31'd0, irq_req0}, 0);
    @(negedge clk); src_in[3] = 1;
    @(negedge clk);
    chk("R11 not after one edge", {31'd0, irq_req0}, 0);
    @(negedge clk);
    chk("R11 after two edges", {31'd0, irq_req0}, 1);
    rd(ST0, v); chk("R7 stat0 level", v, 32'h8);
    src_in[3] = 0; settle();
    chk("R3 high released", {31'd0, irq_req0}, 0);
    set_code(4, 3'b110);
    wr(RTE + 2, 32'h10);
    settle();
    chk("R3 low level req1", {30'd0, irq_req1, irq_req0}, 2'b10);
    rd(ST1, v); chk("R7 stat1", v, 32'h10);
    rd(ST0, v); chk("R7 stat0 empty", v, 0);
    src_in[4] = 1; settle();
    chk("R3 low released", {31'd0, irq_req1}, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    do_reset();
    set_code(8, 3'b001); set_code(9, 3'b010); set_code(10, 3'b011);
    wr(MSK + 1, 32'h700);
    @(negedge clk); src_in[8] = 1; @(negedge clk); src_in[8] = 0;
    settle();
    rd(RISE, v); chk("R4 rise latched", v, 32'h100);
    rd(FALL, v); chk("R4 rise-only no fall", v, 0);
    chk("R4 edge req0", {31'd0, irq_req0}, 1);
    wr(6'h1D, 32'h0);
    rd(RISE, v); chk("R5 zero clear keeps", v, 32'h100);
    wr(6'h1D, 32'h100);
    rd(RISE, v); chk("R5 cleared", v, 0);
    chk("R5 req0 drops", {31'd0, irq_req0}, 0);
    src_in[9] = 1; settle();
    rd(RISE, v); chk("R4 fall mode ignores rise", v, 0);
    chk("R4 fall mode idle", {31'd0, irq_req0}, 0);
    src_in[9] = 0; settle();
    rd(FALL, v); chk("R4 fall latched", v, 32'h200);
    wr(6'h21, 32'h200);
    @(negedge clk); src_in[10] = 1; @(negedge clk); src_in[10] = 0;
    settle();
    rd(RISE, v); chk("R4 both rise", v, 32'h400);
    rd(FALL, v); chk("R4 both fall", v, 32'h400);
    wr(6'h1D, 32'h400);
    chk("R4 both pending on fall", {31'd0, irq_req0}, 1);
    wr(6'h21, 32'h400);
    chk("R5 both acked", {31'd0, irq_req0}, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    do_reset();
    wr(MSK + 1, 32'h1000);
    for (int m = 0; m < 3; m++) begin
      logic [2:0] c;
      c = (m == 0) ? 3'b000 : (m == 1) ? 3'b100 : 3'b111;
      set_code(12, c);
      src_in[12] = 1; settle();
      chk("R6 no pending high", {31'd0, irq_req0}, 0);
      src_in[12] = 0; settle();
      chk("R6 no pending low", {31'd0, irq_req0}, 0);
      rd(RISE, v); chk("R6 no rise capture", v, 0);
      rd(FALL, v); chk("R6 no fall capture", v, 0);
    end
  endtask

  task automatic t_mask_wake();
    logic [31:0] v;
    do_reset();
    set_code(8, 3'b001);
    @(negedge clk); src_in[8] = 1; @(negedge clk); src_in[8] = 0;
    settle();
    rd(RISE, v); chk("R8 masked still latched", v, 32'h100);
    rd(ST0, v);  chk("R8 masked absent", v, 0);
    chk("R8 masked no req", {30'd0, irq_req0, irq_req1}, 0);
    wr(MSK + 1, 32'h100);
    chk("R8 unmask raises req0", {31'd0, irq_req0}, 1);
    wr(MSK + 2, 32'h100);
    wr(WAK + 1, 32'h100);
    chk("R9 wake while masked", {31'd0, irq_wake}, 1);
    chk("R9 no req while masked", {31'd0, irq_req0}, 0);
    wr(6'h1D, 32'h100);
    chk("R9 wake drops", {31'd0, irq_wake}, 0);
  endtask

  task automatic t_storage();
    logic [31:0] v;
    do_reset();
    wr(6'h25, 32'hA5A5_5A5A);
    rd(TST, v); chk("R10 test store", v, 32'hA5A5_5A5A);
    wr(SSEL + 1, 32'hFFFF_FFFF);
    rd(SSEL, v); chk("R10 srcsel store", v, 32'hFFFF_FFFF);
    src_in = 32'hFFFF_FFFF; settle();
    chk("R10 no output effect", {29'd0, irq_req0, irq_req1, irq_wake}, 0);
    rd(RISE, v); chk("R10 no capture", v, 0);
    src_in = '0;
  endtask

  initial begin
    t_reset();
    t_setclr();
    t_level();
    t_edge();
    t_disabled();
    t_mask_wake();
    t_storage();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule